// File: doc/BRIEF.md
# Strided Row DMA Engine

This block copies 8-byte beats between a 4 KB local memory pair (one instruction bank, one data bank) and an external DRAM. A transfer is a number of rows. Each row copies the same number of bytes. On the DRAM side a gap of `skip` bytes is left between rows, and no gap is left after the final row. The local side is packed and wraps around its 4 KB window.

A transfer starts with a one-cycle `start` pulse. On that cycle the engine samples the direction, the two shadow start addresses and the 32-bit transfer configuration word. Each beat takes two cycles: one to read from the source memory and one to write to the destination. When the last beat is written, the live address outputs take the addresses that follow the transfer. The configuration readback then changes to a fixed completion pattern that keeps only the skip field.

Top module: `sdma_engine`

## Requirements
- R1: The configuration word holds the length field in bits 11:0, the row count field in bits 19:12 and the skip field in bits 31:20. Each row moves (length + 1) bytes rounded up to the next multiple of 8.
- R2: A transfer moves count + 1 rows.
- R3: The DRAM start address is taken as `shd_dram_addr & 0xFFFFF8`. The local start offset is taken as `shd_lm_addr[11:0] & 0xFF8`. Every address presented on either memory port is a multiple of 8.
- R4: The local offset wraps modulo 4096 throughout the transfer. Bit 12 of `shd_lm_addr` selects the bank for the whole transfer, with 1 meaning the instruction bank and 0 meaning the data bank. That bank is driven on `lm_isel`.
- R5: After every row except the last, the DRAM address advances by the row length plus the skip and is then cleared to 8-byte alignment. After the last row no skip is added. DRAM bytes inside the skip gaps are left untouched.
- R6: When `to_dram` is 0 at start, data flows from DRAM into local memory. When it is 1, data flows from local memory to DRAM. Only the destination memory is written.
- R7: On completion, `live_dram_addr` holds the DRAM address following the last row. `live_lm_addr` holds the bank select in bit 12 and the advanced local offset in bits 11:0. Both stay unchanged while a transfer runs.
- R8: `cfg_rd` shows the configuration word accepted at start for as long as the transfer runs. On completion it becomes `(skip << 20) | 0xFF8`.
- R9: `busy` rises on the edge that accepts `start` and stays high for exactly 2 × beats-per-row × rows cycles. The final beat is written on the edge where it falls.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: After reset, `busy` is low and `live_dram_addr`, `live_lm_addr` and `cfg_rd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| to_dram | input | 1 | Direction: 1 = local to DRAM, 0 = DRAM to local |
| shd_lm_addr | input | 13 | Shadow local start: bit 12 bank select, 11:0 byte offset |
| shd_dram_addr | input | 24 | Shadow DRAM start byte address |
| xfer_cfg | input | 32 | Length / count / skip configuration word |
| busy | output | 1 | Transfer in progress |
| live_lm_addr | output | 13 | Local address after the last transfer |
| live_dram_addr | output | 24 | DRAM address after the last transfer |
| cfg_rd | output | 32 | Configuration readback |
| dram_req | output | 1 | DRAM access request |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 24 | DRAM beat byte address |
| dram_wdata | output | 64 | DRAM write data |
| dram_rdata | input | 64 | DRAM read data, valid one cycle after a read request |
| lm_req | output | 1 | Local memory access request |
| lm_we | output | 1 | Local memory write enable |
| lm_isel | output | 1 | Local bank select (1 = instruction bank) |
| lm_addr | output | 12 | Local beat byte offset |
| lm_wdata | output | 64 | Local write data |
| lm_rdata | input | 64 | Local read data, valid one cycle after a read request |

## Verification
The tests are built so that each of them isolates one feature. A single-beat, single-row read from DRAM shows that a beat passes through correctly and shows the completion readback. A multi-row read starts from unaligned addresses and uses an odd length and an odd skip, so rounding, masking and the gap after each row can be told apart. A transfer to DRAM with a large skip shows the other direction and shows that the gap bytes are left untouched. A transfer into the instruction bank starting near the top of the 4 KB window shows the wraparound and the bank select. The last test sends a second start in the middle of a transfer. Its result must match a run with no second start, which separates "ignored" from "queued" and from "restarted".

// File: rtl/sdma_pkg.sv
package sdma_pkg;

   // Engine phase: a beat is one FETCH cycle followed by one STORE cycle
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } sdma_state_e;

endpackage

// File: rtl/sdma_row_seq.sv
module sdma_row_seq #(
   parameter int LEN_W      = 12,
   parameter int CNT_W      = 8,
   parameter int BEAT_BYTES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [LEN_W-1:0] len_in,
   input  logic [CNT_W-1:0] cnt_in,
   output logic             row_end,
   output logic             last_row
);
   localparam int ALIGN_B = $clog2(BEAT_BYTES);
   localparam logic [LEN_W-1:0] LOW_ONES = LEN_W'((1 << ALIGN_B) - 1);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] off_q;
   logic [CNT_W-1:0] rows_q;
   logic [CNT_W-1:0] row_q;

   // a row ends when the beat offset reaches the rounded-up row length
   assign row_end  = (off_q | LOW_ONES) == (len_q | LOW_ONES);
   assign last_row = (row_q == rows_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         off_q  <= '0;
         rows_q <= '0;
         row_q  <= '0;
      end else if (load) begin
         len_q  <= len_in;
         rows_q <= cnt_in;
         off_q  <= '0;
         row_q  <= '0;
      end else if (step) begin
         if (row_end) begin
            off_q <= '0;
            row_q <= row_q + 1'b1;
         end else begin
            off_q <= off_q + LEN_W'(BEAT_BYTES);
         end
      end
   end

   // R2: the row index never passes the programmed count while stepping
   a_r2_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last_row) |=> (row_q <= rows_q));

endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
   parameter int DRAM_AW    = 24,
   parameter int LM_AW      = 12,
   parameter int SKIP_W     = 12,
   parameter int BEAT_BYTES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               row_end,
   input  logic               last_row,
   input  logic [DRAM_AW-1:0] dram_start,
   input  logic [LM_AW-1:0]   lm_start,
   input  logic [SKIP_W-1:0]  skip_in,
   output logic [DRAM_AW-1:0] dram_cur,
   output logic [LM_AW-1:0]   lm_cur,
   output logic [DRAM_AW-1:0] dram_nxt,
   output logic [LM_AW-1:0]   lm_nxt
);
   localparam int ALIGN_B = $clog2(BEAT_BYTES);
   localparam logic [DRAM_AW-1:0] D_MASK = ~DRAM_AW'((1 << ALIGN_B) - 1);
   localparam logic [LM_AW-1:0]   L_MASK = ~LM_AW'((1 << ALIGN_B) - 1);

   logic [SKIP_W-1:0]  skip_q;
   logic [DRAM_AW-1:0] skip_ext;
   logic [DRAM_AW-1:0] gap;

   // pick how the skip field maps onto the DRAM address width
   generate
      if (SKIP_W >= DRAM_AW) begin : g_skip_trunc
         assign skip_ext = skip_q[DRAM_AW-1:0];
      end else begin : g_skip_zext
         assign skip_ext = {{(DRAM_AW-SKIP_W){1'b0}}, skip_q};
      end
   endgenerate

   assign gap      = (row_end && !last_row) ? skip_ext : '0;
   assign dram_nxt = (dram_cur + DRAM_AW'(BEAT_BYTES) + gap) & D_MASK;
   assign lm_nxt   = (lm_cur + LM_AW'(BEAT_BYTES)) & L_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_cur <= '0;
         lm_cur   <= '0;
         skip_q   <= '0;
      end else if (load) begin
         dram_cur <= dram_start & D_MASK;
         lm_cur   <= lm_start & L_MASK;
         skip_q   <= skip_in;
      end else if (step) begin
         dram_cur <= dram_nxt;
         lm_cur   <= lm_nxt;
      end
   end

   // R5: inside a row the DRAM cursor moves by exactly one beat
   a_r5_in_row_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !row_end && !load) |=> (dram_cur == $past(dram_cur) + DRAM_AW'(BEAT_BYTES)));

   // R4: the local cursor moves one beat per step, wrapping in its window
   a_r4_lm_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (lm_cur == LM_AW'($past(lm_cur) + LM_AW'(BEAT_BYTES))));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
   import sdma_pkg::*;
#(
   parameter int DRAM_AW    = 24,
   parameter int LM_AW      = 12,
   parameter int LEN_W      = 12,
   parameter int CNT_W      = 8,
   parameter int SKIP_W     = 12,
   parameter int BEAT_BYTES = 8,
   localparam int DW        = BEAT_BYTES * 8,
   localparam int CFG_W     = LEN_W + CNT_W + SKIP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               to_dram,
   input  logic [LM_AW:0]     shd_lm_addr,
   input  logic [DRAM_AW-1:0] shd_dram_addr,
   input  logic [CFG_W-1:0]   xfer_cfg,
   output logic               busy,
   output logic [LM_AW:0]     live_lm_addr,
   output logic [DRAM_AW-1:0] live_dram_addr,
   output logic [CFG_W-1:0]   cfg_rd,
   output logic               dram_req,
   output logic               dram_we,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic [DW-1:0]      dram_wdata,
   input  logic [DW-1:0]      dram_rdata,
   output logic               lm_req,
   output logic               lm_we,
   output logic               lm_isel,
   output logic [LM_AW-1:0]   lm_addr,
   output logic [DW-1:0]      lm_wdata,
   input  logic [DW-1:0]      lm_rdata
);
   localparam int ALIGN_B = $clog2(BEAT_BYTES);
   localparam logic [LEN_W-1:0] LEN_DONE = {{(LEN_W-ALIGN_B){1'b1}}, {ALIGN_B{1'b0}}};

   // elaboration-time parameter checks
   generate
      if ((1 << ALIGN_B) != BEAT_BYTES) begin : g_chk_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if (LEN_W > LM_AW) begin : g_chk_len
         $error("row length field wider than local window");
      end
      if (ALIGN_B >= LEN_W) begin : g_chk_align
         $error("length field narrower than beat alignment");
      end
   endgenerate

   sdma_state_e        state_q;
   logic               dir_q;
   logic               sel_q;
   logic [CFG_W-1:0]   cfg_q;
   logic [DRAM_AW-1:0] live_dram_q;
   logic [LM_AW:0]     live_lm_q;

   logic               load, step, done;
   logic               row_end, last_row;
   logic [DRAM_AW-1:0] dram_cur, dram_nxt;
   logic [LM_AW-1:0]   lm_cur, lm_nxt;

   assign load = (state_q == ST_IDLE) && start;
   assign step = (state_q == ST_STORE);
   assign done = step && row_end && last_row;

   sdma_row_seq #(
      .LEN_W      (LEN_W),
      .CNT_W      (CNT_W),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .len_in   (xfer_cfg[LEN_W-1:0]),
      .cnt_in   (xfer_cfg[LEN_W +: CNT_W]),
      .row_end  (row_end),
      .last_row (last_row)
   );

   sdma_addr_gen #(
      .DRAM_AW    (DRAM_AW),
      .LM_AW      (LM_AW),
      .SKIP_W     (SKIP_W),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .row_end    (row_end),
      .last_row   (last_row),
      .dram_start (shd_dram_addr),
      .lm_start   (shd_lm_addr[LM_AW-1:0]),
      .skip_in    (xfer_cfg[CFG_W-1 -: SKIP_W]),
      .dram_cur   (dram_cur),
      .lm_cur     (lm_cur),
      .dram_nxt   (dram_nxt),
      .lm_nxt     (lm_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         dir_q       <= 1'b0;
         sel_q       <= 1'b0;
         cfg_q       <= '0;
         live_dram_q <= '0;
         live_lm_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_FETCH;
                  dir_q   <= to_dram;
                  sel_q   <= shd_lm_addr[LM_AW];
                  cfg_q   <= xfer_cfg;
               end
            end
            ST_FETCH: state_q <= ST_STORE;
            ST_STORE: begin
               if (done) begin
                  state_q     <= ST_IDLE;
                  live_dram_q <= dram_nxt;
                  live_lm_q   <= {sel_q, lm_nxt};
                  cfg_q       <= {cfg_q[CFG_W-1 -: SKIP_W], {CNT_W{1'b0}}, LEN_DONE};
               end else begin
                  state_q <= ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic fetch_ph, store_ph;
   assign fetch_ph = (state_q == ST_FETCH);
   assign store_ph = (state_q == ST_STORE);

   always_comb begin
      dram_req = (fetch_ph && !dir_q) || (store_ph && dir_q);
      dram_we  = store_ph && dir_q;
      lm_req   = (fetch_ph && dir_q) || (store_ph && !dir_q);
      lm_we    = store_ph && !dir_q;
   end

   assign dram_addr      = dram_cur;
   assign lm_addr        = lm_cur;
   assign lm_isel        = sel_q;
   assign dram_wdata     = lm_rdata;
   assign lm_wdata       = dram_rdata;
   assign busy           = (state_q != ST_IDLE);
   assign live_dram_addr = live_dram_q;
   assign live_lm_addr   = live_lm_q;
   assign cfg_rd         = cfg_q;

   // R9: an accepted start raises busy on the next cycle
   a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R3: every port address is beat aligned
   a_r3_dram_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      dram_req |-> (dram_addr[ALIGN_B-1:0] == '0));

   // R6: at most one memory is written in any cycle
   a_r6_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dram_req && dram_we, lm_req && lm_we}));

   // R8: completion leaves the fixed length pattern and a zero count
   a_r8_done_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cfg_rd[LEN_W+CNT_W-1:0] == {{CNT_W{1'b0}}, LEN_DONE}));

   // R10: configuration readback cannot change mid-transfer
   a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_rd));

   // R7: live addresses only move on completion
   a_r7_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(live_dram_addr) && $stable(live_lm_addr)));

endmodule

// File: tb/sdma_engine_test.sv
`timescale 1ns/1ps
module sdma_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        to_dram = 1'b0;
   logic [12:0] shd_lm_addr = '0;
   logic [23:0] shd_dram_addr = '0;
   logic [31:0] xfer_cfg = '0;
   logic        busy;
   logic [12:0] live_lm_addr;
   logic [23:0] live_dram_addr;
   logic [31:0] cfg_rd;
   logic        dram_req, dram_we, lm_req, lm_we, lm_isel;
   logic [23:0] dram_addr;
   logic [11:0] lm_addr;
   logic [63:0] dram_wdata, lm_wdata;
   logic [63:0] dram_rdata = '0;
   logic [63:0] lm_rdata = '0;

   always #2 clk = ~clk;   // 250 MHz

   sdma_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .to_dram(to_dram),
      .shd_lm_addr(shd_lm_addr), .shd_dram_addr(shd_dram_addr), .xfer_cfg(xfer_cfg),
      .busy(busy), .live_lm_addr(live_lm_addr), .live_dram_addr(live_dram_addr),
      .cfg_rd(cfg_rd), .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .lm_req(lm_req), .lm_we(lm_we),
      .lm_isel(lm_isel), .lm_addr(lm_addr), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
   );

   // memory models: one-cycle synchronous read, 8-byte words
   logic [63:0] dram_m [0:8191];
   logic [63:0] imem_m [0:511];
   logic [63:0] dmem_m [0:511];
   logic [63:0] dram_x [0:8191];
   logic [63:0] imem_x [0:511];
   logic [63:0] dmem_x [0:511];

   always @(posedge clk) begin
      if (dram_req) begin
         if (dram_we) dram_m[dram_addr[15:3]] <= dram_wdata;
         else         dram_rdata <= dram_m[dram_addr[15:3]];
      end
      if (lm_req) begin
         if (lm_we) begin
            if (lm_isel) imem_m[lm_addr[11:3]] <= lm_wdata;
            else         dmem_m[lm_addr[11:3]] <= lm_wdata;
         end else begin
            lm_rdata <= lm_isel ? imem_m[lm_addr[11:3]] : dmem_m[lm_addr[11:3]];
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   logic [23:0] exp_dram;
   logic [12:0] exp_lm;
   logic [31:0] exp_cfg;
   int          exp_cyc;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference built from the requirements, applied to the expected images
   task automatic ref_model(input bit dir, input logic [12:0] lsh,
                            input logic [23:0] dsh, input logic [31:0] cfg);
      int rowlen = ((int'(cfg[11:0]) + 1 + 7) / 8) * 8;
      int rows   = int'(cfg[19:12]) + 1;
      logic [23:0] d = dsh & 24'hFFFFF8;
      logic [11:0] l = lsh[11:0] & 12'hFF8;
      for (int i = 0; i < 8192; i++) dram_x[i] = dram_m[i];
      for (int i = 0; i < 512; i++) begin imem_x[i] = imem_m[i]; dmem_x[i] = dmem_m[i]; end
      for (int r = 0; r < rows; r++) begin
         for (int j = 0; j < rowlen; j += 8) begin
            logic [23:0] da;
            logic [11:0] la;
            da = d + 24'(j);
            la = l + 12'(j);
            if (dir) dram_x[da[15:3]] = lsh[12] ? imem_x[la[11:3]] : dmem_x[la[11:3]];
            else if (lsh[12]) imem_x[la[11:3]] = dram_x[da[15:3]];
            else dmem_x[la[11:3]] = dram_x[da[15:3]];
         end
         d = (d + 24'(rowlen) + ((r == rows - 1) ? 24'd0 : 24'(cfg[31:20]))) & 24'hFFFFF8;
         l = (l + 12'(rowlen)) & 12'hFF8;
      end
      exp_dram = d;
      exp_lm   = {lsh[12], l};
      exp_cfg  = {cfg[31:20], 8'h00, 12'hFF8};
      exp_cyc  = 2 * (rowlen / 8) * rows;
   endtask

   task automatic cmp_mem(input string req);
      int mm = 0;
      for (int i = 0; i < 8192; i++) if (dram_m[i] !== dram_x[i]) mm++;
      for (int i = 0; i < 512; i++) begin
         if (imem_m[i] !== imem_x[i]) mm++;
         if (dmem_m[i] !== dmem_x[i]) mm++;
      end
      chk(mm == 0, req, "memory image mismatched words", 64'(mm), 64'd0);
   endtask

   // one scenario: launch, optionally poke a second start, check everything
   task automatic run_xfer(input string req, input bit dir, input logic [12:0] lsh,
                           input logic [23:0] dsh, input logic [31:0] cfg, input bit intrude);
      int n = 0;
      ref_model(dir, lsh, dsh, cfg);
      @(negedge clk);
      start = 1'b1; to_dram = dir; shd_lm_addr = lsh; shd_dram_addr = dsh; xfer_cfg = cfg;
      @(negedge clk);
      start = 1'b0;
      chk(cfg_rd === cfg, "R8", "readback while running", 64'(cfg_rd), 64'(cfg));
      while (busy && n < 20000) begin
         n++;
         if (intrude && n == 3) begin   // R10 stimulus
            start = 1'b1; to_dram = ~dir; shd_lm_addr = 13'h0ABC;
            shd_dram_addr = 24'h00F123; xfer_cfg = 32'h0A1_02_0FF;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(n == exp_cyc, "R9", {req, " busy cycles"}, 64'(n), 64'(exp_cyc));
      chk(live_dram_addr === exp_dram, "R7 R5", {req, " live dram"}, 64'(live_dram_addr), 64'(exp_dram));
      chk(live_lm_addr === exp_lm, "R7 R4", {req, " live local"}, 64'(live_lm_addr), 64'(exp_lm));
      chk(cfg_rd === exp_cfg, "R8", {req, " completion readback"}, 64'(cfg_rd), 64'(exp_cfg));
      cmp_mem(req);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R10", {req, " no second transfer"}, 64'(busy), 64'd0);
   endtask

   task automatic t_reset();
      chk(busy === 1'b0, "R11", "busy after reset", 64'(busy), 64'd0);
      chk(live_dram_addr === '0, "R11", "live dram after reset", 64'(live_dram_addr), 64'd0);
      chk(live_lm_addr === '0, "R11", "live local after reset", 64'(live_lm_addr), 64'd0);
      chk(cfg_rd === '0, "R11", "readback after reset", 64'(cfg_rd), 64'd0);
   endtask

   // R1 R6: single aligned beat, DRAM into data bank
   task automatic t_single(); run_xfer("R1 R6 single", 1'b0, 13'h0040, 24'h000100, 32'h000_00_007, 1'b0); endtask
   // R1 R2 R3 R5: unaligned starts, odd length and odd skip
   task automatic t_strided_read(); run_xfer("R1 R2 R3 R5 strided", 1'b0, 13'h0123, 24'h000205, 32'h005_02_00A, 1'b0); endtask
   // R6 R5: local to DRAM, gaps must keep their old contents
   task automatic t_write(); run_xfer("R6 R5 write", 1'b1, 13'h0200, 24'h003000, 32'h020_03_00F, 1'b0); endtask
   // R4: instruction bank, offset wraps past 4 KB
   task automatic t_wrap(); run_xfer("R4 wrap", 1'b0, 13'h1FF0, 24'h004000, 32'h008_01_01F, 1'b0); endtask
   // R4 R6: instruction bank out to DRAM, large skip
   task automatic t_imem_out(); run_xfer("R4 R6 imem out", 1'b1, 13'h1808, 24'h006007, 32'h3F9_02_017, 1'b0); endtask
   // R10: start pulse mid-transfer
   task automatic t_intrude(); run_xfer("R10 intrude", 1'b0, 13'h0300, 24'h005000, 32'h010_02_017, 1'b1); endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8192; i++) dram_m[i] = {32'hD000_0000 | 32'(i), 32'(i) * 32'h9E37_79B9};
      for (int i = 0; i < 512; i++) begin
         imem_m[i] = {32'h1100_0000 | 32'(i), ~(32'(i) * 32'h85EB_CA6B)};
         dmem_m[i] = {32'hDD00_0000 | 32'(i), 32'(i) * 32'hC2B2_AE35};
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_strided_read();
      t_write();
      t_wrap();
      t_imem_out();
      t_intrude();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule